// File: doc/BRIEF.md
# Seconds Counter with Masked Wake Alarm

This peripheral keeps time as a binary count of seconds. A reference-clock enable, qualified on every core clock cycle, feeds a programmable divider. The divider emits one tick every (divider value + 1) qualified cycles, and each tick advances a 62-bit seconds count. Software drives the block through a 32-bit register bus. Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. The control word carries write-one commands: start, stop, alarm arm, alarm disarm, counter reset, upload and download. Reading the control word returns status.

A new time is not written straight into the counter. Software writes two shadow words and then issues an upload command. The commit happens one cycle later, and the control word then reports that the upload is done. A download command copies the live count back into the shadows. On every tick the alarm compares the new count with a 43-bit alarm value under a bit mask. A match raises a sticky wake interrupt, which only a disarm command or a counter reset removes.

Sequencing is held in a four-state machine:
- **HALTED**: stopped. A start goes to COUNTING. An upload goes to LOAD_HALTED, or to LOAD_COUNTING when a start arrives in the same write and no stop does.
- **COUNTING**: running. A stop goes to HALTED. An upload goes to LOAD_COUNTING, or to LOAD_HALTED when a stop arrives with it.
- **LOAD_HALTED** and **LOAD_COUNTING**: the commit cycle. The shadows are copied into the count, the divider count restarts and the done flag is set. The next state is HALTED or COUNTING, chosen from the run state carried by the load state after applying any start or stop written in that cycle. A new upload in that cycle enters a load state again.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset the control word reads 0, both time words read 0, the divider reads 0, the mask words read 0xFFFFFFFF (offset 0x14) and 0x3FFFFFFF (offset 0x18), and `wake_irq` is 0.
- R2: Registers read back with their implemented widths, and bits above those widths read 0. Divider at 0x08 has 26 bits. Mode at 0x04 has 4 bits, and its bit 1 is wake enable. Alarm low at 0x0C has 32 bits and alarm high at 0x10 has 11 bits, giving alarm bits 42:32. Mask low at 0x14 has 32 bits and mask high at 0x18 has 30 bits.
- R3: While running with `ref_en` high, the count read at 0x20 (bits 31:0) and 0x24 (bits 61:32) rises by one every divider+1 cycles. With `ref_en` low the count does not move. The count wraps from all ones to 0.
- R4: Writing 0x20 or 0x24 changes only the shadows. Control bit 5 (upload) commits the shadows to the count on the next edge. Control read bit 5 is 0 from the request until the commit and 1 afterwards.
- R5: Control bit 0 starts and bit 1 stops, and stop wins when both are written. Control read bit 0 shows the running state. A stopped count holds its value.
- R6: Control bit 4 clears the count, the divider count and the match flag, and leaves the divider register unchanged. An upload written together with it is ignored.
- R7: Control bit 6 copies the count value that is present on the cycle of the write into the shadows.
- R8: When the alarm is armed (control bit 2) and wake enable is set, a tick whose new count matches the alarm on every mask bit sets `wake_irq` and control read bit 7.
- R9: The match is sticky. Control bit 3 clears it and disarms the alarm, and disarm wins over arm when both are written.
- R10: Alarm bits whose mask bit is 0 do not take part in the compare.
- R11: With wake enable clear, no match is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | Reference-clock qualifier; one divider step per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wake_irq | output | 1 | Sticky alarm interrupt |

## Verification
The interesting collisions are commands that land on a cycle in which the count is also being changed by something else. A stop-plus-upload write is issued while ticks arrive every cycle, so the tick, the stop and the later commit fall on adjacent edges. A reset-plus-upload write is issued to show that the clear wins and the shadows never reach the count. In each case the bench works out, from the edge count alone, which value the count must hold one cycle later. A sticky match that meets a simultaneous arm and disarm is judged by watching `wake_irq` stay low while the count passes further masked matches.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_HALTED,
        ST_COUNTING,
        ST_LOAD_HALTED,
        ST_LOAD_COUNTING
    } seq_state_t;

    localparam int BUS_AW = 6;

    localparam logic [BUS_AW-1:0] OFS_CTRL   = 6'h00;
    localparam logic [BUS_AW-1:0] OFS_MODE   = 6'h04;
    localparam logic [BUS_AW-1:0] OFS_DIV    = 6'h08;
    localparam logic [BUS_AW-1:0] OFS_ALM_LO = 6'h0C;
    localparam logic [BUS_AW-1:0] OFS_ALM_HI = 6'h10;
    localparam logic [BUS_AW-1:0] OFS_MSK_LO = 6'h14;
    localparam logic [BUS_AW-1:0] OFS_MSK_HI = 6'h18;
    localparam logic [BUS_AW-1:0] OFS_TIM_LO = 6'h20;
    localparam logic [BUS_AW-1:0] OFS_TIM_HI = 6'h24;

    localparam int CB_START  = 0;
    localparam int CB_STOP   = 1;
    localparam int CB_ARM    = 2;
    localparam int CB_DISARM = 3;
    localparam int CB_CLEAR  = 4;
    localparam int CB_UPLOAD = 5;
    localparam int CB_DNLOAD = 6;
    localparam int CB_MATCH  = 7;

    localparam int MB_WAKE_EN = 1;

endpackage

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic cmd_upload,
    input  logic cmd_clear,
    output logic running,
    output logic commit,
    output logic load_ack
);

    seq_state_t state_q, state_d;
    logic       base_run;
    logic       want_run;
    logic       take_load;

    assign take_load = cmd_upload && !cmd_clear;
    assign want_run  = cmd_stop ? 1'b0 : (cmd_start ? 1'b1 : base_run);

    always_comb begin
        base_run = 1'b0;
        unique case (state_q)
            ST_HALTED:        base_run = 1'b0;
            ST_COUNTING:      base_run = 1'b1;
            ST_LOAD_HALTED:   base_run = 1'b0;
            ST_LOAD_COUNTING: base_run = 1'b1;
        endcase
        if (take_load)
            state_d = want_run ? ST_LOAD_COUNTING : ST_LOAD_HALTED;
        else
            state_d = want_run ? ST_COUNTING : ST_HALTED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        running = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_HALTED:        ;
            ST_COUNTING:      running = 1'b1;
            ST_LOAD_HALTED:   commit  = 1'b1;
            ST_LOAD_COUNTING: begin
                running = 1'b1;
                commit  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         load_ack <= 1'b0;
        else if (take_load) load_ack <= 1'b0;
        else if (commit)    load_ack <= 1'b1;
    end

    // R5
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> !running);

    // R4
    upload_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_upload && !cmd_clear) |=> (commit && !load_ack));

    // R6
    clear_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clear && !commit) |=> !commit);

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int DIV_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;

    assign tick = step && !restart && (phase_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (step)    phase_q <= tick ? '0 : phase_q + 1'b1;
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || limit == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(phase_q));

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
    parameter int ALM_W = 43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [ALM_W-1:0] next_count,
    input  logic [ALM_W-1:0] alarm,
    input  logic [ALM_W-1:0] mask,
    input  logic             wake_en,
    input  logic             cmd_arm,
    input  logic             cmd_disarm,
    input  logic             cmd_clear,
    output logic             armed,
    output logic             irq
);

    logic hit;

    assign hit = tick && armed && wake_en && (((next_count ^ alarm) & mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          armed <= 1'b0;
        else if (cmd_disarm) armed <= 1'b0;
        else if (cmd_arm)    armed <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      irq <= 1'b0;
        else if (cmd_disarm || cmd_clear) irq <= 1'b0;
        else if (hit)                    irq <= 1'b1;
    end

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cmd_disarm && !cmd_clear) |=> irq);

    // R9
    disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disarm |=> (!irq && !armed));

    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick && armed && wake_en));

endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
    import rtc_pkg::*;
#(
    parameter int CNT_W  = 62,
    parameter int ALM_W  = 43,
    parameter int DIV_W  = 26,
    parameter int MODE_W = 4,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              wake_irq
);

    localparam int CNT_HI_W = CNT_W - DW;
    localparam int ALM_HI_W = ALM_W - DW;

    logic [DIV_W-1:0]    div_q;
    logic [MODE_W-1:0]   mode_q;
    logic [DW-1:0]       alm_lo_q, msk_lo_q, shd_lo_q;
    logic [ALM_HI_W-1:0] alm_hi_q;
    logic [CNT_HI_W-1:0] msk_hi_q, shd_hi_q;
    logic [CNT_W-1:0]    cnt_q, cnt_inc;
    logic [CNT_W-1:0]    msk_full;

    logic ctrl_wr;
    logic cmd_start, cmd_stop, cmd_arm, cmd_disarm, cmd_clear, cmd_upload, cmd_dnload;
    logic running, commit, load_ack, tick, armed, irq;

    assign ctrl_wr    = bus_wr && (bus_addr == OFS_CTRL);
    assign cmd_start  = ctrl_wr && bus_wdata[CB_START];
    assign cmd_stop   = ctrl_wr && bus_wdata[CB_STOP];
    assign cmd_arm    = ctrl_wr && bus_wdata[CB_ARM];
    assign cmd_disarm = ctrl_wr && bus_wdata[CB_DISARM];
    assign cmd_clear  = ctrl_wr && bus_wdata[CB_CLEAR];
    assign cmd_upload = ctrl_wr && bus_wdata[CB_UPLOAD];
    assign cmd_dnload = ctrl_wr && bus_wdata[CB_DNLOAD];

    rtc_seq_fsm u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .cmd_upload (cmd_upload),
        .cmd_clear  (cmd_clear),
        .running    (running),
        .commit     (commit),
        .load_ack   (load_ack)
    );

    rtc_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (running && ref_en),
        .restart (cmd_clear || commit),
        .limit   (div_q),
        .tick    (tick)
    );

    assign cnt_inc  = cnt_q + 1'b1;
    assign msk_full = {msk_hi_q, msk_lo_q};

    rtc_alarm_unit #(.ALM_W(ALM_W)) u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .next_count (cnt_inc[ALM_W-1:0]),
        .alarm      ({alm_hi_q, alm_lo_q}),
        .mask       (msk_full[ALM_W-1:0]),
        .wake_en    (mode_q[MB_WAKE_EN]),
        .cmd_arm    (cmd_arm),
        .cmd_disarm (cmd_disarm),
        .cmd_clear  (cmd_clear),
        .armed      (armed),
        .irq        (irq)
    );

    assign wake_irq = irq;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q    <= '0;
            mode_q   <= '0;
            alm_lo_q <= '0;
            alm_hi_q <= '0;
            msk_lo_q <= '1;
            msk_hi_q <= '1;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_DIV:    div_q    <= bus_wdata[DIV_W-1:0];
                OFS_MODE:   mode_q   <= bus_wdata[MODE_W-1:0];
                OFS_ALM_LO: alm_lo_q <= bus_wdata;
                OFS_ALM_HI: alm_hi_q <= bus_wdata[ALM_HI_W-1:0];
                OFS_MSK_LO: msk_lo_q <= bus_wdata;
                OFS_MSK_HI: msk_hi_q <= bus_wdata[CNT_HI_W-1:0];
                default: ;
            endcase
        end
    end

    // shadow time words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_lo_q <= '0;
            shd_hi_q <= '0;
        end else if (cmd_dnload) begin
            shd_lo_q <= cnt_q[DW-1:0];
            shd_hi_q <= cnt_q[CNT_W-1:DW];
        end else if (bus_wr && bus_addr == OFS_TIM_LO) begin
            shd_lo_q <= bus_wdata;
        end else if (bus_wr && bus_addr == OFS_TIM_HI) begin
            shd_hi_q <= bus_wdata[CNT_HI_W-1:0];
        end
    end

    // live seconds count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (cmd_clear) cnt_q <= '0;
        else if (commit)    cnt_q <= {shd_hi_q, shd_lo_q};
        else if (tick)      cnt_q <= cnt_inc;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[CB_START]  = running;
                bus_rdata[CB_UPLOAD] = load_ack;
                bus_rdata[CB_MATCH]  = irq;
            end
            OFS_MODE:   bus_rdata = {{(DW-MODE_W){1'b0}}, mode_q};
            OFS_DIV:    bus_rdata = {{(DW-DIV_W){1'b0}}, div_q};
            OFS_ALM_LO: bus_rdata = alm_lo_q;
            OFS_ALM_HI: bus_rdata = {{(DW-ALM_HI_W){1'b0}}, alm_hi_q};
            OFS_MSK_LO: bus_rdata = msk_lo_q;
            OFS_MSK_HI: bus_rdata = {{(DW-CNT_HI_W){1'b0}}, msk_hi_q};
            OFS_TIM_LO: bus_rdata = cnt_q[DW-1:0];
            OFS_TIM_HI: bus_rdata = {{(DW-CNT_HI_W){1'b0}}, cnt_q[CNT_W-1:DW]};
            default:    bus_rdata = '0;
        endcase
    end

    // R5
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cmd_clear && !commit) |=> $stable(cnt_q));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clear |=> (cnt_q == '0 && !irq));

    // R8
    irq_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_irq) |-> $past(armed));

endmodule

// File: tb/tb_rtc_alarm_core.sv
module tb_rtc_alarm_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wake_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_alarm_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_en    (ref_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wake_irq  (wake_irq)
    );

    typedef struct packed {
        logic [5:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{6'h08, 32'hFFFF_FFFF, 32'h03FF_FFFF},
        '{6'h04, 32'hFFFF_FFFF, 32'h0000_000F},
        '{6'h0C, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
        '{6'h10, 32'hFFFF_FFFF, 32'h0000_07FF},
        '{6'h14, 32'h1234_5678, 32'h1234_5678},
        '{6'h18, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
        '{6'h18, 32'h0000_0000, 32'h0000_0000},
        '{6'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
    };

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr %h got %h exp %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        #1;
        n_chk++;
        if (wake_irq !== exp) begin
            n_bad++;
            $display("FAIL %s wake_irq got %b exp %b", tag, wake_irq, exp);
        end
    endtask

    task automatic upload_time(input logic [31:0] lo, input logic [31:0] hi);
        wr(6'h20, lo);
        wr(6'h24, hi);
        wr(6'h00, 32'h20);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 ctrl", 6'h00, 32'h0);
        chk("R1 tlo", 6'h20, 32'h0);
        chk("R1 thi", 6'h24, 32'h0);
        chk("R1 div", 6'h08, 32'h0);
        chk("R1 mlo", 6'h14, 32'hFFFF_FFFF);
        chk("R1 mhi", 6'h18, 32'h3FFF_FFFF);
        chk_irq("R1 irq", 1'b0);

        // R2 register widths through the vector table
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].a, VECS[i].w);
            chk("R2 readback", VECS[i].a, VECS[i].e);
        end

        // R3 tick period with divider 3
        wr(6'h08, 32'd3);
        wr(6'h04, 32'h0);
        wr(6'h00, 32'h01);
        repeat (40) @(negedge clk);
        chk("R3 ten ticks", 6'h20, 32'd10);
        chk("R5 running", 6'h00, 32'h01);
        ref_en = 1'b0;
        repeat (20) @(negedge clk);
        chk("R3 ref_en low", 6'h20, 32'd10);
        ref_en = 1'b1;
        wr(6'h00, 32'h02);
        chk("R5 stopped", 6'h00, 32'h0);
        repeat (20) @(negedge clk);
        chk("R5 hold", 6'h20, 32'd10);
        wr(6'h00, 32'h03);
        repeat (8) @(negedge clk);
        chk("R5 stop wins", 6'h00, 32'h0);
        chk("R5 still held", 6'h20, 32'd10);

        // R4 shadow and upload handshake
        wr(6'h20, 32'h100);
        wr(6'h24, 32'hFFFF_FFFF);
        chk("R4 shadow only", 6'h20, 32'd10);
        wr(6'h00, 32'h20);
        chk("R4 ack low", 6'h00, 32'h0);
        chk("R4 not yet", 6'h20, 32'd10);
        @(negedge clk);
        chk("R4 commit lo", 6'h20, 32'h100);
        chk("R4 commit hi", 6'h24, 32'h3FFF_FFFF);
        chk("R4 ack high", 6'h00, 32'h20);

        // R7 download while ticking every cycle
        wr(6'h08, 32'd0);
        wr(6'h00, 32'h01);
        repeat (9) @(negedge clk);
        chk("R3 div0", 6'h20, 32'h109);
        wr(6'h00, 32'h40);
        wr(6'h00, 32'h22);
        @(negedge clk);
        chk("R7 download lo", 6'h20, 32'h10A);
        chk("R7 download hi", 6'h24, 32'h3FFF_FFFF);
        chk("R5 stop with upload", 6'h00, 32'h20);

        // R3 wrap
        upload_time(32'hFFFF_FFFF, 32'h3FFF_FFFF);
        wr(6'h00, 32'h01);
        @(negedge clk);
        chk("R3 wrap lo", 6'h20, 32'h0);
        chk("R3 wrap hi", 6'h24, 32'h0);
        wr(6'h00, 32'h02);

        // R6 reset beats upload, divider kept
        wr(6'h08, 32'd5);
        wr(6'h00, 32'h30);
        @(negedge clk);
        chk("R6 cleared lo", 6'h20, 32'h0);
        chk("R6 cleared hi", 6'h24, 32'h0);
        chk("R6 upload ignored", 6'h00, 32'h20);
        chk("R6 divider kept", 6'h08, 32'd5);

        // R8 full-mask alarm at count 20
        wr(6'h08, 32'd0);
        upload_time(32'h0, 32'h0);
        wr(6'h14, 32'hFFFF_FFFF);
        wr(6'h18, 32'h3FFF_FFFF);
        wr(6'h0C, 32'd20);
        wr(6'h10, 32'h0);
        wr(6'h04, 32'h2);
        wr(6'h00, 32'h05);
        repeat (19) @(negedge clk);
        chk_irq("R8 before match", 1'b0);
        chk("R8 count 19", 6'h20, 32'd19);
        @(negedge clk);
        chk_irq("R8 match", 1'b1);
        chk("R8 ctrl match", 6'h00, 32'hA1);
        repeat (10) @(negedge clk);
        chk_irq("R9 sticky", 1'b1);
        wr(6'h00, 32'h08);
        chk_irq("R9 disarm clears", 1'b0);
        chk("R9 ctrl", 6'h00, 32'h21);

        // R11 wake enable clear
        wr(6'h00, 32'h02);
        upload_time(32'h0, 32'h0);
        wr(6'h0C, 32'd5);
        wr(6'h04, 32'h0);
        wr(6'h00, 32'h05);
        repeat (10) @(negedge clk);
        chk_irq("R11 no wake", 1'b0);

        // R10 masked compare: alarm 7, mask 3 -> first hit at 3
        wr(6'h00, 32'h0A);
        upload_time(32'h0, 32'h0);
        wr(6'h0C, 32'd7);
        wr(6'h14, 32'h3);
        wr(6'h18, 32'h0);
        wr(6'h04, 32'h2);
        wr(6'h00, 32'h05);
        repeat (2) @(negedge clk);
        chk_irq("R10 before", 1'b0);
        @(negedge clk);
        chk_irq("R10 masked hit", 1'b1);

        // R9 disarm wins over arm
        wr(6'h00, 32'h0C);
        chk_irq("R9 off+on clears", 1'b0);
        repeat (8) @(negedge clk);
        chk_irq("R9 off wins", 1'b0);

        // R6 reset clears the match flag
        wr(6'h00, 32'h04);
        repeat (4) @(negedge clk);
        chk_irq("R6 rearmed hit", 1'b1);
        wr(6'h00, 32'h10);
        chk_irq("R6 match cleared", 1'b0);
        chk("R6 count zero", 6'h20, 32'h0);
        chk("R6 ctrl", 6'h00, 32'h21);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule